// File: doc/BRIEF.md
# Streaming Phase-to-Sine Converter with Selectable Spur Reduction

This block is the amplitude stage of a direct digital synthesizer. Each beat on its AXI4-Stream input carries one phase word. Each beat on its AXI4-Stream output carries the matching sine and cosine sample. The sine sits in the low half of the output word and the cosine in the high half. A quarter-wave table, built in code when the design is elaborated, supplies the samples. The top phase bits pick the quadrant, and that choice decides the address mirroring and the sign.

A static mode input chooses how the phase bits below the table resolution are handled:

- **Truncation:** the low bits are dropped.
- **Dithered truncation:** a pseudo-random value, always smaller than one table step, is added to the phase before the low bits are dropped. This decorrelates the quantization error.
- **First-order Taylor correction:** the dropped residue is used to correct both table outputs.

Every mode accepts one sample per clock. Each mode has a fixed latency, and the Taylor mode needs two stages more than the other modes. Back-pressure on the output stalls the whole pipeline, so no sample is lost or repeated. The last-beat flag travels through the pipeline with its sample. The mode may only be changed while the pipeline is empty.

Top module: `dds_phase_to_sine`

## Requirements
- R1: During reset and directly after it, m_tvalid is 0 and s_tready is 1.
- R2: For modes 2'b00 (truncation) and 2'b11, the result is the table sample at the truncated index. With m_tready held high, the output handshake for a sample falls on the second rising edge after the edge that accepted it.
- R3: The table entry T[k] is round(AMP·sin(2π(k+0.5)/4096)) for k = 0..1023, with AMP = 32000.
  - The index is i = phase[31:20], the quadrant is q = i[11:10] and the address is a = i[9:0].
  - If q is odd, the table is read at 1023−a. If q ≥ 2, the value is negated.
  - The cosine is the same lookup at index i+1024 (mod 4096).
  - m_tdata is {cos[31:16], sin[15:0]}, both signed two's complement.
- R4: In mode 2'b01 (dither), each result equals the R3 sample for index i or for index i+1 (mod 4096).
- R5: In dither mode, the same mid-step phase (phase[19:0] = 0x80000) sent 64 times produces both neighbouring samples at least once.
- R6: In mode 2'b10 (Taylor), the result is within 1 LSB of the corrected values below, using the R3 values S and C for index i.
  - sin = S + C·Δ and cos = C − S·Δ, where Δ = (2π/4096)·(phase[19:0] − 2^19)/2^20.
  - With m_tready held high, the output handshake falls on the fourth rising edge after the accepting edge.
- R7: Under back-pressure, results leave in input order with none lost or duplicated. While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values.
- R8: m_tlast on each output beat equals s_tlast of the input beat that produced it.
- R9: While m_tready is high, s_tready is high, so a continuous input stream is accepted at one beat per clock without a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Spur-reduction method: 00 truncate, 01 dither, 10 Taylor, 11 truncate |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high together with s_tvalid |
| s_tdata | input | 32 | Phase word |
| s_tlast | input | 1 | Last beat of a block |
| m_tvalid | output | 1 | Output sample valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 32 | {cosine, sine}, 16-bit signed each |
| m_tlast | output | 1 | Last flag aligned with its sample |

## Verification
The bench builds the block with its default parameters: a 32-bit phase, a 12-bit full-wave index over a 1024-entry quarter table, 16-bit outputs and a 20-bit residue. With these values, every quadrant boundary and both phase extremes can be driven directly, and a mid-step residue is placed exactly where dither must reach both neighbouring entries. The 20-bit residue lets the Taylor correction be compared against an independent real-valued model. The bench computes its own table and correction, sends streams with a gated ready pattern, and measures each mode's latency on the output handshake.

// File: rtl/dds_pkg.sv
package dds_pkg;
    typedef enum logic [1:0] {
        MODE_TRUNC  = 2'b00,
        MODE_DITHER = 2'b01,
        MODE_TAYLOR = 2'b10,
        MODE_SPARE  = 2'b11
    } dds_mode_e;

    localparam real TWO_PI = 6.283185307179586;
endpackage

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr #(
    parameter int          DW   = 20,
    parameter logic [31:0] SEED = 32'h1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [DW-1:0] value
);
    typedef struct packed {
        logic [31:0] lfsr;
    } lfsr_t;

    lfsr_t st_d, st_q;

    // polynomial x^32 + x^22 + x^2 + x + 1, maximal length
    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.lfsr = {st_q.lfsr[30:0],
                         st_q.lfsr[31] ^ st_q.lfsr[21] ^ st_q.lfsr[1] ^ st_q.lfsr[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lfsr: SEED};
        else        st_q <= st_d;
    end

    assign value = st_q.lfsr[DW-1:0];
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom
    import dds_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OUT_W  = 16,
    parameter int AMP    = 32000
) (
    input  logic [ADDR_W-1:0]        idx,
    output logic signed [OUT_W-1:0]  sin_val,
    output logic signed [OUT_W-1:0]  cos_val
);
    localparam int QA    = ADDR_W - 2;
    localparam int QD    = 1 << QA;
    localparam real FULL = real'(1 << ADDR_W);
    localparam logic [ADDR_W-1:0] QSTEP = ADDR_W'(QD);

    logic signed [OUT_W-1:0] wave_rom [QD];

    initial begin
        for (int k = 0; k < QD; k++) begin
            wave_rom[k] = OUT_W'($rtoi(real'(AMP) * $sin(TWO_PI * (real'(k) + 0.5) / FULL) + 0.5));
        end
    end

    function automatic logic signed [OUT_W-1:0] fetch(input logic [ADDR_W-1:0] i);
        logic [QA-1:0]           a;
        logic signed [OUT_W-1:0] t;
        a = i[ADDR_W-2] ? ~i[QA-1:0] : i[QA-1:0];
        t = wave_rom[a];
        return i[ADDR_W-1] ? -t : t;
    endfunction

    always_comb begin
        sin_val = fetch(idx);
        cos_val = fetch(idx + QSTEP);
    end
endmodule

// File: rtl/dds_taylor.sv
module dds_taylor
    import dds_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OUT_W  = 16,
    parameter int RES_W  = 20,
    parameter int KSH    = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic signed [OUT_W-1:0] sin_in,
    input  logic signed [OUT_W-1:0] cos_in,
    input  logic signed [RES_W-1:0] res_in,
    output logic                    out_valid,
    output logic                    out_last,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);
    localparam int PW = OUT_W + RES_W;
    localparam int KC = $rtoi(TWO_PI * (2.0 ** (KSH - ADDR_W)) + 0.5);
    localparam int KW = $clog2(KC + 1) + 1;
    localparam int FW = PW + KW;
    localparam int SH = RES_W + KSH;
    localparam logic signed [KW-1:0] KCONST = KW'(KC);
    localparam logic signed [FW-1:0] RND    = FW'(1) << (SH - 1);
    localparam logic signed [FW-1:0] VMAX   = FW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [FW-1:0] VMIN   = -VMAX - FW'(1);

    typedef struct packed {
        logic                    valid;
        logic                    last;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
        logic signed [PW-1:0]    cr;
        logic signed [PW-1:0]    sr;
    } prod_t;

    typedef struct packed {
        logic                    valid;
        logic                    last;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } sum_t;

    prod_t p_d, p_q;
    sum_t  r_d, r_q;

    logic signed [FW-1:0] mc, ms, tc, ts, ssum, csum;

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [FW-1:0] v);
        if (v > VMAX)      return OUT_W'(VMAX);
        else if (v < VMIN) return OUT_W'(VMIN);
        else               return OUT_W'(v);
    endfunction

    always_comb begin
        p_d = p_q;
        r_d = r_q;
        mc   = FW'(p_q.cr) * FW'(KCONST);
        ms   = FW'(p_q.sr) * FW'(KCONST);
        tc   = (mc + RND) >>> SH;
        ts   = (ms + RND) >>> SH;
        ssum = FW'(p_q.s) + tc;
        csum = FW'(p_q.c) - ts;
        if (en) begin
            p_d.valid = in_valid;
            p_d.last  = in_last;
            p_d.s     = sin_in;
            p_d.c     = cos_in;
            p_d.cr    = PW'(cos_in) * PW'(res_in);
            p_d.sr    = PW'(sin_in) * PW'(res_in);
            r_d.valid = p_q.valid;
            r_d.last  = p_q.last;
            r_d.s     = clip(ssum);
            r_d.c     = clip(csum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
            r_q <= '0;
        end else begin
            p_q <= p_d;
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.valid;
    assign out_last  = r_q.last;
    assign sin_out   = r_q.s;
    assign cos_out   = r_q.c;
endmodule

// File: rtl/dds_phase_to_sine.sv
module dds_phase_to_sine
    import dds_pkg::*;
#(
    parameter int          PHASE_W = 32,
    parameter int          ADDR_W  = 12,
    parameter int          OUT_W   = 16,
    parameter int          AMP     = 32000,
    parameter int          KSH     = 24,
    parameter logic [31:0] SEED    = 32'h1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 s_tvalid,
    output logic                 s_tready,
    input  logic [PHASE_W-1:0]   s_tdata,
    input  logic                 s_tlast,
    output logic                 m_tvalid,
    input  logic                 m_tready,
    output logic [2*OUT_W-1:0]   m_tdata,
    output logic                 m_tlast
);
    localparam int RES_W = PHASE_W - ADDR_W;

    typedef struct packed {
        logic                valid;
        logic                last;
        logic [ADDR_W-1:0]   idx;
        logic signed [RES_W-1:0] res;
    } quant_t;

    typedef struct packed {
        logic                    valid;
        logic                    last;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
        logic signed [RES_W-1:0] res;
    } look_t;

    quant_t q_d, q_q;
    look_t  l_d, l_q;

    logic                    en;
    logic [RES_W-1:0]        dither;
    logic [PHASE_W-1:0]      phase_sum;
    logic signed [OUT_W-1:0] rom_s, rom_c;
    logic                    ty_valid, ty_last;
    logic signed [OUT_W-1:0] ty_s, ty_c;
    logic                    use_taylor;

    assign use_taylor = (mode == MODE_TAYLOR);
    assign en         = !m_tvalid || m_tready;
    assign s_tready   = en;

    dds_dither_lfsr #(.DW(RES_W), .SEED(SEED)) u_dither (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (s_tvalid && en),
        .value   (dither)
    );

    dds_quarter_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .AMP(AMP)) u_rom (
        .idx     (q_q.idx),
        .sin_val (rom_s),
        .cos_val (rom_c)
    );

    always_comb begin
        q_d = q_q;
        l_d = l_q;
        phase_sum = s_tdata + ((mode == MODE_DITHER) ? PHASE_W'(dither) : '0);
        if (en) begin
            q_d.valid = s_tvalid;
            q_d.last  = s_tlast;
            q_d.idx   = phase_sum[PHASE_W-1 -: ADDR_W];
            q_d.res   = {~phase_sum[RES_W-1], phase_sum[RES_W-2:0]};
            l_d.valid = q_q.valid;
            l_d.last  = q_q.last;
            l_d.s     = rom_s;
            l_d.c     = rom_c;
            l_d.res   = q_q.res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
            l_q <= '0;
        end else begin
            q_q <= q_d;
            l_q <= l_d;
        end
    end

    dds_taylor #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .RES_W(RES_W), .KSH(KSH)) u_taylor (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .in_valid  (l_q.valid),
        .in_last   (l_q.last),
        .sin_in    (l_q.s),
        .cos_in    (l_q.c),
        .res_in    (l_q.res),
        .out_valid (ty_valid),
        .out_last  (ty_last),
        .sin_out   (ty_s),
        .cos_out   (ty_c)
    );

    always_comb begin
        if (use_taylor) begin
            m_tvalid = ty_valid;
            m_tlast  = ty_last;
            m_tdata  = {ty_c, ty_s};
        end else begin
            m_tvalid = l_q.valid;
            m_tlast  = l_q.last;
            m_tdata  = {l_q.c, l_q.s};
        end
    end
endmodule

// File: rtl/dds_phase_to_sine_chk.sv
module dds_phase_to_sine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          s_tvalid,
    input logic          s_tready,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic [DW-1:0] m_tdata,
    input logic          m_tlast
);
    logic accept;
    assign accept = s_tvalid && s_tready;

    // R7
    hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R9
    ready_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tready |-> s_tready);

    // R2
    short_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept && mode != 2'b10) && s_tready |=> m_tvalid);

    // R6
    long_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept && mode == 2'b10, 3) && $past(s_tready, 2) && $past(s_tready, 1) && s_tready
        |=> m_tvalid);
endmodule

bind dds_phase_to_sine dds_phase_to_sine_chk #(.DW(2*OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast)
);

// File: tb/dds_phase_to_sine_test.sv
module dds_phase_to_sine_test;
    localparam real TWO_PI = 6.283185307179586;
    localparam real AMP    = 32000.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [31:0] s_tdata = '0;
    logic        s_tlast = 1'b0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [31:0] m_tdata;
    logic        m_tlast;

    always #4 clk = ~clk;

    dds_phase_to_sine uut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
    );

    typedef struct {
        string tag;
        int    es, ec, as_, ac, tol;
        bit    alt, last, chk_lat;
        int    acc_cyc, lat;
    } exp_t;

    exp_t q[$];
    int   checks = 0, failures = 0;
    int   cyc = 0, stalls = 0;
    int   hit_main = 0, hit_alt = 0;
    bit   bp = 1'b0, chk_lat = 1'b0, done = 1'b0;
    int   rcnt = 0;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int tab(input int k);
        return $rtoi(AMP * $sin(TWO_PI * (real'(k) + 0.5) / 4096.0) + 0.5);
    endfunction

    function automatic int look(input int i);
        int qd, a, t;
        i  = i & 4095;
        qd = i >> 10;
        a  = i & 1023;
        if (qd % 2 == 1) a = 1023 - a;
        t = tab(a);
        return (qd >= 2) ? -t : t;
    endfunction

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        @(negedge clk);
        rcnt++;
        m_tready = bp ? ((rcnt % 3 != 0) && (rcnt % 7 != 3)) : 1'b1;
    end

    task automatic send(input logic [31:0] p, input bit last, input string tag);
        exp_t e;
        int   idx, s0, c0;
        real  d;
        idx = int'(p >> 20);
        e.tag = tag; e.last = last; e.alt = 0; e.tol = 0;
        e.es = look(idx); e.ec = look(idx + 1024);
        e.as_ = 0; e.ac = 0;
        e.lat = (mode == 2'b10) ? 4 : 2;
        e.chk_lat = chk_lat;
        if (mode == 2'b01) begin
            e.alt = 1; e.as_ = look(idx + 1); e.ac = look(idx + 1025);
        end else if (mode == 2'b10) begin
            s0 = e.es; c0 = e.ec;
            d = TWO_PI / 4096.0 * ((real'(p & 32'h000F_FFFF) - 524288.0) / 1048576.0);
            e.es = rnd(real'(s0) + real'(c0) * d);
            e.ec = rnd(real'(c0) - real'(s0) * d);
            e.tol = 1;
        end
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = p; s_tlast = last;
        #1;
        while (!s_tready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        e.acc_cyc = cyc + 1;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        idle();
        while (q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
        check(q.size() == 0, "R7", "pending results", q.size(), 0);
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    initial forever begin
        exp_t e;
        int   as, ac;
        @(negedge clk);
        #1;
        if (rst_n && m_tvalid && m_tready) begin
            as = int'($signed(m_tdata[15:0]));
            ac = int'($signed(m_tdata[31:16]));
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected output beat", as, 0);
            end else begin
                e = q.pop_front();
                if (e.alt) begin
                    if (as == e.es && ac == e.ec) hit_main++;
                    else if (as == e.as_ && ac == e.ac) hit_alt++;
                    check((as == e.es && ac == e.ec) || (as == e.as_ && ac == e.ac),
                          e.tag, "dither sin", as, e.es);
                end else begin
                    check(absd(as, e.es) <= e.tol, e.tag, "sin", as, e.es);
                    check(absd(ac, e.ec) <= e.tol, e.tag, "cos", ac, e.ec);
                end
                check(m_tlast == e.last, "R8", "tlast", int'(m_tlast), int'(e.last));
                if (e.chk_lat)
                    check(cyc + 1 - e.acc_cyc == e.lat, e.tag, "latency", cyc + 1 - e.acc_cyc, e.lat);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] edges [8];
        edges[0] = 32'h0000_0000; edges[1] = 32'h3FFF_FFFF;
        edges[2] = 32'h4000_0000; edges[3] = 32'h7FFF_FFFF;
        edges[4] = 32'h8000_0000; edges[5] = 32'hBFFF_FFFF;
        edges[6] = 32'hC000_0000; edges[7] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        check(m_tvalid == 1'b0, "R1", "m_tvalid in reset", int'(m_tvalid), 0);
        check(s_tready == 1'b1, "R1", "s_tready in reset", int'(s_tready), 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(m_tvalid == 1'b0, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
        check(s_tready == 1'b1, "R1", "s_tready after reset", int'(s_tready), 1);

        // R2 latency with a single beat, truncation
        mode = 2'b00; chk_lat = 1;
        send(32'h1234_5678, 1'b1, "R2");
        drain();
        // R3 quadrant edges and symmetric pairs
        for (int i = 0; i < 8; i++) send(edges[i], i == 7, "R3");
        for (int i = 0; i < 64; i++) begin
            send(32'h0123_4567 * i, 1'b0, "R3");
            send(32'h0123_4567 * i + 32'h8000_0000, 1'b0, "R3");
        end
        // R9 continuous stream with ready high: no stall
        stalls = 0;
        for (int i = 0; i < 100; i++) send(32'h0279_3A11 * i, (i % 10) == 9, "R2");
        check(stalls == 0, "R9", "input stalls", stalls, 0);
        drain();
        // R5 truncation at mid-step gives only the main neighbour
        for (int i = 0; i < 8; i++) send(32'h2A38_0000 | 32'h0008_0000, 1'b0, "R2");
        drain();

        // R7 / R8 back-pressure in truncation mode
        chk_lat = 0; bp = 1;
        for (int i = 0; i < 300; i++) send(32'h9E37_79B9 * i, (i % 16) == 15, "R7");
        drain();
        bp = 0;

        // R4 dither sweep with back-pressure
        mode = 2'b01; bp = 1;
        for (int i = 0; i < 300; i++) send(32'h6A09_E667 * i, (i % 16) == 15, "R4");
        drain();
        bp = 0;
        // R5 dither at mid-step reaches both neighbours
        hit_main = 0; hit_alt = 0;
        for (int i = 0; i < 64; i++) send(32'h5C18_0000 | 32'h0008_0000, i == 63, "R5");
        drain();
        check(hit_main > 0, "R5", "main neighbour count", hit_main, 1);
        check(hit_alt > 0, "R5", "next neighbour count", hit_alt, 1);

        // R6 Taylor: latency, edges, sweep, back-pressure
        mode = 2'b10; chk_lat = 1;
        send(32'h0ABC_DEF1, 1'b1, "R6");
        drain();
        for (int i = 0; i < 8; i++) send(edges[i], 1'b0, "R6");
        stalls = 0;
        for (int i = 0; i < 200; i++) send(32'hBB67_AE85 * i, (i % 8) == 7, "R6");
        check(stalls == 0, "R9", "taylor input stalls", stalls, 0);
        drain();
        chk_lat = 0; bp = 1;
        for (int i = 0; i < 300; i++) send(32'h3C6E_F372 * i + 32'h0000_1234, (i % 16) == 15, "R7");
        drain();
        bp = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule